// File: doc/BRIEF.md
# Thirty-Two Pin I/O Port with Edge Event Latching

This block is a 32-pin general-purpose I/O port on a simple synchronous register bus. For each pin, software chooses whether the block drives it and whether the driver works open-drain. Software also holds the level the pin is driven to. Every pin's input is brought into the clock domain through two flops. The block then compares each synchronised value with its previous value to find rising and falling edges.

Edges that the selected edge rule accepts are held in an event register, where software clears them by writing ones. A mask register gates the events, and the gated events combine into a single interrupt line. A parameter picks one of two edge-rule layouts. The narrow layout uses one control bit per pin. The wide layout uses a two-bit code per pin, spread over two control words, and in this layout the last four pins can only be inputs.

Bus reads are combinational. While the read enable is high, the read data shows the addressed word. At all other times it is zero.

Top module: `pin_event_port`

## Requirements
- R1: After reset, every register reads zero, pinOe and pinOut are all zero, and irq is low.
- R2: Pin n is port bit n on pinIn, pinOut and pinOe, and it is register bit 31-n in every bus word, so pin 0 is the MSB.
- R3: Word offsets are as follows: 0x00 direction, 0x04 open-drain enable, 0x08 data, 0x0C events, 0x10 mask, 0x14 edge control, and 0x18 the second edge-control word (wide layout only). A direction bit of 1 makes the pin an output with pinOe high, and pinOut always carries the data bit.
- R4: When an output pin has open-drain enabled, its pinOe is high only while its data bit is 0.
- R5: Reading data returns the data bit for output pins and the synchronised input level for input pins. An input change is visible after two rising clock edges.
- R6: Writing a 1 to an event bit clears it. Writing a 0 leaves it unchanged. An edge latches into the event register at the third rising clock edge after the pin changes.
- R7: irq is high exactly when some bit is set in both the event register and the mask register.
- R8: In the narrow layout, a control bit of 1 latches only falling edges, and a control bit of 0 latches both rising and falling edges.
- R9: In the wide layout, pins 0 to 15 take their codes from word 0x14 and pins 16 to 31 from word 0x18. Pin p uses bits starting at 2*(15-(p mod 16)). Code 00 latches both edges, 01 latches rising edges, 10 latches falling edges, and 11 latches nothing.
- R10: In the wide layout, the direction bits of pins 28 to 31 read 0 and ignore writes, so those pins are never driven.
- R11: If an edge is latched in the same cycle as a write that clears its bit, the edge wins and the bit stays set.
- R12: Reads of unmapped offsets return zero. This includes 0x18 in the narrow layout. Read data is zero while busRe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Byte address of the word |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRe | input | 1 | Read enable |
| busRdata | output | 32 | Combinational read data |
| pinIn | input | 32 | Pin levels, bit n is pin n |
| pinOut | output | 32 | Level to drive, bit n is pin n |
| pinOe | output | 32 | Driver enable, bit n is pin n |
| irq | output | 1 | Combined masked interrupt |

## Verification
The case that is hardest to reach from the ports is an edge that meets a clear. This happens when the cycle in which the synchronised edge becomes visible is the same cycle in which a write of ones to the event word arrives. The bench changes a pin just after a falling clock edge and waits two more falling edges. It then issues the clearing write, so the write lands on the rising edge that would latch the event. It does this for both a rising and a falling edge, with another pending event present that must still be cleared. The edge-rule layouts are swept over every pin and every code, with only the target pin's field enabled, so a misplaced field shows up as a missing event.

// File: rtl/pep_pkg.sv
package pep_pkg;
  localparam int PORT_W = 32;
  localparam int LOCKED_PINS = 4;

  typedef enum logic [2:0] {
    SEL_DIR  = 3'd0,
    SEL_ODR  = 3'd1,
    SEL_DAT  = 3'd2,
    SEL_EVT  = 3'd3,
    SEL_MSK  = 3'd4,
    SEL_CTL  = 3'd5,
    SEL_CTL2 = 3'd6,
    SEL_NONE = 3'd7
  } regSel_t;

  typedef struct packed {
    logic    wrDir;
    logic    wrOdr;
    logic    wrDat;
    logic    wrEvt;
    logic    wrMsk;
    logic    wrCtl;
    logic    wrCtl2;
    regSel_t rdSel;
  } busStrobe_t;
endpackage

// File: rtl/pep_ctrl.sv
module pep_ctrl
  import pep_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter bit WIDE_SEL = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  output busStrobe_t        st
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic [1:0]       addrUnused;
  regSel_t          hitSel;

  assign wordIdx    = busAddr[ADDR_W-1:2];
  assign addrUnused = busAddr[1:0];

  always_comb begin
    case (wordIdx)
      IDX_W'(0): hitSel = SEL_DIR;
      IDX_W'(1): hitSel = SEL_ODR;
      IDX_W'(2): hitSel = SEL_DAT;
      IDX_W'(3): hitSel = SEL_EVT;
      IDX_W'(4): hitSel = SEL_MSK;
      IDX_W'(5): hitSel = SEL_CTL;
      IDX_W'(6): hitSel = WIDE_SEL ? SEL_CTL2 : SEL_NONE;
      default:   hitSel = SEL_NONE;
    endcase
  end

  always_comb begin
    st.rdSel  = busRe ? hitSel : SEL_NONE;
    st.wrDir  = busWe && (hitSel == SEL_DIR);
    st.wrOdr  = busWe && (hitSel == SEL_ODR);
    st.wrDat  = busWe && (hitSel == SEL_DAT);
    st.wrEvt  = busWe && (hitSel == SEL_EVT);
    st.wrMsk  = busWe && (hitSel == SEL_MSK);
    st.wrCtl  = busWe && (hitSel == SEL_CTL);
    st.wrCtl2 = busWe && (hitSel == SEL_CTL2);
  end

  // R12: at most one word written per cycle, none for unmapped offsets
  a_r12_one_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.wrDir, st.wrOdr, st.wrDat, st.wrEvt, st.wrMsk, st.wrCtl, st.wrCtl2}));

  // R12: the second control word never exists in the narrow layout
  a_r12_no_ctl2_narrow: assert property (@(posedge clk) disable iff (!rstN)
    !WIDE_SEL |-> !st.wrCtl2);
endmodule

// File: rtl/pep_datapath.sv
module pep_datapath
  import pep_pkg::*;
#(
  parameter bit WIDE_SEL = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        st,
  input  logic [PORT_W-1:0] wdata,
  input  logic [PORT_W-1:0] pinIn,
  output logic [PORT_W-1:0] rdata,
  output logic [PORT_W-1:0] pinOut,
  output logic [PORT_W-1:0] pinOe,
  output logic              irq
);
  localparam int HALF = PORT_W / 2;
  localparam logic [PORT_W-1:0] DIR_MASK =
    WIDE_SEL ? {{(PORT_W-LOCKED_PINS){1'b1}}, {LOCKED_PINS{1'b0}}} : {PORT_W{1'b1}};

  logic [PORT_W-1:0] dirReg, odrReg, datReg, evtReg, mskReg, ctlReg, ctl2Reg;
  logic [PORT_W-1:0] inBits, syncA, syncB, prevB;
  logic [PORT_W-1:0] riseV, fallV, hitV, oeBits, clrV;

  // pin n <-> register bit PORT_W-1-n
  for (genvar p = 0; p < PORT_W; p++) begin : g_map
    assign inBits[PORT_W-1-p] = pinIn[p];
    assign pinOe[p]           = oeBits[PORT_W-1-p];
    assign pinOut[p]          = datReg[PORT_W-1-p];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= inBits;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  assign riseV = syncB & ~prevB;
  assign fallV = ~syncB & prevB;

  for (genvar b = 0; b < PORT_W; b++) begin : g_edge
    if (WIDE_SEL) begin : g_wide
      logic [1:0] code;
      if (b >= HALF) begin : g_lo
        assign code = ctlReg[2*(b-HALF) +: 2];
      end else begin : g_hi
        assign code = ctl2Reg[2*b +: 2];
      end
      assign hitV[b] = ((code == 2'b00) && (riseV[b] || fallV[b])) ||
                       ((code == 2'b01) && riseV[b]) ||
                       ((code == 2'b10) && fallV[b]);
    end else begin : g_narrow
      assign hitV[b] = fallV[b] || (riseV[b] && !ctlReg[b]);
    end
  end

  assign clrV = st.wrEvt ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirReg  <= '0;
      odrReg  <= '0;
      datReg  <= '0;
      evtReg  <= '0;
      mskReg  <= '0;
      ctlReg  <= '0;
      ctl2Reg <= '0;
    end else begin
      if (st.wrDir)  dirReg  <= wdata & DIR_MASK;
      if (st.wrOdr)  odrReg  <= wdata;
      if (st.wrDat)  datReg  <= wdata;
      if (st.wrMsk)  mskReg  <= wdata;
      if (st.wrCtl)  ctlReg  <= wdata;
      if (st.wrCtl2) ctl2Reg <= wdata;
      evtReg <= (evtReg & ~clrV) | hitV;
    end
  end

  assign oeBits = dirReg & ~(odrReg & datReg);
  assign irq    = |(evtReg & mskReg);

  always_comb begin
    case (st.rdSel)
      SEL_DIR:  rdata = dirReg;
      SEL_ODR:  rdata = odrReg;
      SEL_DAT:  rdata = (datReg & dirReg) | (syncB & ~dirReg);
      SEL_EVT:  rdata = evtReg;
      SEL_MSK:  rdata = mskReg;
      SEL_CTL:  rdata = ctlReg;
      SEL_CTL2: rdata = ctl2Reg;
      default:  rdata = '0;
    endcase
  end

  // R6: a full clear with no new edge empties the event word
  a_r6_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrEvt && (wdata == '1) && (hitV == '0)) |=> (evtReg == '0));

  // R6: an event bit only rises when an accepted edge was seen
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    (hitV == '0) |=> ((evtReg & ~$past(evtReg)) == '0));

  // R11: an accepted edge is always latched, even against a clear
  a_r11_edge_wins: assert property (@(posedge clk) disable iff (!rstN)
    (hitV != '0) |=> ((evtReg & $past(hitV)) == $past(hitV)));

  // R7: with nothing unmasked the interrupt stays low
  a_r7_mask_gate: assert property (@(posedge clk) disable iff (!rstN)
    (mskReg == '0) |-> !irq);

  // R4: an open-drain output holding a 1 is never driven
  a_r4_od_release: assert property (@(posedge clk) disable iff (!rstN)
    ((odrReg & datReg & oeBits) == '0));

  if (WIDE_SEL) begin : g_lock_chk
    // R10: the input-only pins are never driven
    a_r10_input_only: assert property (@(posedge clk) disable iff (!rstN)
      (pinOe[PORT_W-1 -: LOCKED_PINS] == '0));
  end
endmodule

// File: rtl/pin_event_port.sv
module pin_event_port
  import pep_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter bit WIDE_SEL = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [PORT_W-1:0] busWdata,
  input  logic              busRe,
  output logic [PORT_W-1:0] busRdata,
  input  logic [PORT_W-1:0] pinIn,
  output logic [PORT_W-1:0] pinOut,
  output logic [PORT_W-1:0] pinOe,
  output logic              irq
);
  busStrobe_t st;

  pep_ctrl #(.ADDR_W(ADDR_W), .WIDE_SEL(WIDE_SEL)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe), .st(st)
  );

  pep_datapath #(.WIDE_SEL(WIDE_SEL)) uPath (
    .clk(clk), .rstN(rstN), .st(st), .wdata(busWdata), .pinIn(pinIn),
    .rdata(busRdata), .pinOut(pinOut), .pinOe(pinOe), .irq(irq)
  );
endmodule

// File: tb/sim_pin_event_port.sv
`timescale 1ns/1ps
module sim_pin_event_port;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] busAddr = '0;
  logic busWe = 1'b0;
  logic busRe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] p0 = '0, p1 = '0;
  logic [31:0] rd0, rd1, out0, out1, oe0, oe1;
  logic irq0, irq1;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] v0, v1;

  always #5 clk = ~clk;

  pin_event_port #(.WIDE_SEL(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRe(busRe), .busRdata(rd0), .pinIn(p0), .pinOut(out0), .pinOe(oe0), .irq(irq0));

  pin_event_port #(.WIDE_SEL(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRe(busRe), .busRdata(rd1), .pinIn(p1), .pinOut(out1), .pinOe(oe1), .irq(irq1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b1; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] r0, output logic [31:0] r1);
    @(negedge clk);
    busAddr = a; busRe = 1'b1;
    #1;
    r0 = rd0; r1 = rd1;
    busRe = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(5'(a * 4), v0, v1);
      chk("R1 u0 reg", v0, 32'h0);
      chk("R1 u1 reg", v1, 32'h0);
    end
    chk("R1 oe", oe0 | oe1, 32'h0);
    chk("R1 out", out0 | out1, 32'h0);
    chk("R1 irq", {30'h0, irq0, irq1}, 32'h0);

    // R2 R3: pins 0,1 as outputs, pin 0 high
    wr(5'h00, 32'hC000_0000);
    wr(5'h08, 32'h8000_0000);
    #1;
    chk("R2 pinOe order", oe0, 32'h0000_0003);
    chk("R3 pinOut", out1, 32'h0000_0001);
    rd(5'h00, v0, v1);
    chk("R3 dir readback", v1, 32'hC000_0000);

    // R4: open drain
    wr(5'h04, 32'hC000_0000);
    #1;
    chk("R4 od high released", oe0, 32'h0000_0002);
    wr(5'h08, 32'h4000_0000);
    #1;
    chk("R4 od low driven", oe1, 32'h0000_0001);
    wr(5'h04, 32'h0);
    wr(5'h08, 32'h8000_0000);

    // R5: mixed data read
    @(negedge clk);
    p0 = 32'h0000_0023;
    repeat (2) @(negedge clk);
    rd(5'h08, v0, v1);
    chk("R5 data mix", v0, 32'h8400_0000);
    wr(5'h00, 32'h0);
    wr(5'h08, 32'h0);
    @(negedge clk);
    p0 = 32'h0;
    repeat (4) @(negedge clk);
    wr(5'h0C, 32'hFFFF_FFFF);

    // R8: narrow layout sweep
    for (int c = 0; c < 2; c++) begin
      wr(5'h14, (c != 0) ? 32'hFFFF_FFFF : 32'h0);
      for (int n = 0; n < 32; n++) begin
        @(negedge clk); p0[n] = 1'b1;
        repeat (3) @(negedge clk);
        rd(5'h0C, v0, v1);
        chk("R8 rise", v0, (c != 0) ? 32'h0 : (32'h8000_0000 >> n));
        wr(5'h0C, 32'hFFFF_FFFF);
        @(negedge clk); p0[n] = 1'b0;
        repeat (3) @(negedge clk);
        rd(5'h0C, v0, v1);
        chk("R8 fall", v0, 32'h8000_0000 >> n);
        wr(5'h0C, 32'hFFFF_FFFF);
      end
    end

    // R9: wide layout sweep, only the target field enabled
    for (int n = 0; n < 32; n++) begin
      for (int code = 0; code < 4; code++) begin
        logic [31:0] c1, c2;
        c1 = 32'hFFFF_FFFF; c2 = 32'hFFFF_FFFF;
        if (n < 16) c1[2*(15-n) +: 2] = 2'(code);
        else        c2[2*(31-n) +: 2] = 2'(code);
        wr(5'h14, c1);
        wr(5'h18, c2);
        @(negedge clk); p1[n] = 1'b1;
        repeat (3) @(negedge clk);
        rd(5'h0C, v0, v1);
        chk("R9 rise", v1, (code == 0 || code == 1) ? (32'h8000_0000 >> n) : 32'h0);
        wr(5'h0C, 32'hFFFF_FFFF);
        @(negedge clk); p1[n] = 1'b0;
        repeat (3) @(negedge clk);
        rd(5'h0C, v0, v1);
        chk("R9 fall", v1, (code == 0 || code == 2) ? (32'h8000_0000 >> n) : 32'h0);
        wr(5'h0C, 32'hFFFF_FFFF);
      end
    end

    // R6: partial clears
    wr(5'h14, 32'h0);
    @(negedge clk); p0[2:0] = 3'b111;
    repeat (3) @(negedge clk);
    rd(5'h0C, v0, v1);
    chk("R6 three events", v0, 32'hE000_0000);
    wr(5'h0C, 32'h4000_0000);
    rd(5'h0C, v0, v1);
    chk("R6 one cleared", v0, 32'hA000_0000);
    wr(5'h0C, 32'h0);
    rd(5'h0C, v0, v1);
    chk("R6 zero write no effect", v0, 32'hA000_0000);

    // R7: mask gating
    #1;
    chk("R7 no mask", {31'h0, irq0}, 32'h0);
    wr(5'h10, 32'h2000_0000);
    #1;
    chk("R7 masked event", {31'h0, irq0}, 32'h1);
    wr(5'h10, 32'h4000_0000);
    #1;
    chk("R7 mask on cleared bit", {31'h0, irq0}, 32'h0);
    wr(5'h10, 32'hFFFF_FFFF);
    wr(5'h0C, 32'hFFFF_FFFF);
    #1;
    chk("R7 all cleared", {31'h0, irq0}, 32'h0);
    wr(5'h10, 32'h0);

    // R11: edge and clear in the same cycle, another event pending
    @(negedge clk); p0[4] = 1'b1;
    repeat (4) @(negedge clk);
    p0[3] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    busAddr = 5'h0C; busWe = 1'b1; busWdata = 32'hFFFF_FFFF;
    @(negedge clk);
    busWe = 1'b0;
    rd(5'h0C, v0, v1);
    chk("R11 rise beats clear", v0, 32'h1000_0000);
    @(negedge clk); p0[3] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    busAddr = 5'h0C; busWe = 1'b1; busWdata = 32'hFFFF_FFFF;
    @(negedge clk);
    busWe = 1'b0;
    rd(5'h0C, v0, v1);
    chk("R11 fall beats clear", v0, 32'h1000_0000);
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h0C, v0, v1);
    chk("R11 later clear works", v0, 32'h0);

    // R10: input-only pins in the wide layout
    @(negedge clk); p1[31:28] = 4'b1010;
    wr(5'h00, 32'hFFFF_FFFF);
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h00, v0, v1);
    chk("R10 dir narrow", v0, 32'hFFFF_FFFF);
    chk("R10 dir wide", v1, 32'hFFFF_FFF0);
    chk("R10 oe wide", oe1, 32'h0FFF_FFFF);
    rd(5'h08, v0, v1);
    chk("R10 data wide", v1, 32'hFFFF_FFF5);

    // R12: unmapped offsets
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h18, v0, v1);
    chk("R12 narrow 0x18", v0, 32'h0);
    chk("R12 wide 0x18", v1, 32'hFFFF_FFFF);
    rd(5'h1C, v0, v1);
    chk("R12 0x1C", v0 | v1, 32'h0);
    @(negedge clk);
    busAddr = 5'h00;
    #1;
    chk("R12 no read enable", rd0 | rd1, 32'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule